// File: doc/BRIEF.md
# Age-Ordered Load Slot Allocator

This block hands out slots of a small buffer to as many as three load ports that can ask in the same cycle. Each port presents a valid bit and its reorder-buffer age. The age is an index plus a wrap flag. The buffer presents a vector that marks which of its slots are free this cycle.

Valid requests are ranked oldest first. The k-th oldest valid request receives the k-th free slot, counting free slots upward from slot 0. Idle ports take no part in the ranking, so they use up no slot. A valid request left without a slot raises its reject flag, and the pipeline then rolls that load back.

Ranking by age rather than by port number keeps the oldest load from being starved when the buffer is small. The whole decision is combinational and is taken within one cycle. All pins are plain control signals: there is no handshake and no back-pressure, and a grant is simply valid while the inputs are held.

Top module: `load_slot_alloc`

## Requirements
- R1: A port with `req_vld` high and `gnt_rej` low is granted the slot number on its `gnt_slot` field. Port p uses bits [p*SW +: SW] of `gnt_slot`, where SW = clog2(NSLOT).
- R2: Valid requests are served oldest first. The oldest valid request gets the lowest-numbered free slot, the next oldest gets the next free slot upward, and so on.
- R3: Each age field is AGE_W+1 bits wide. Port p uses bits [p*(AGE_W+1) +: AGE_W+1], and the top bit of the field is the wrap flag. When two ages have equal flags, the smaller index is older. When the flags differ, the larger index is older.
- R4: Ports with `req_vld` low are skipped. With only port 2 valid and only slot 2 free, port 2 is granted slot 2.
- R5: A valid request is rejected only if all free slots have gone to older requests. Whenever any port is rejected, every free slot has been granted.
- R6: A granted slot is always free, and no slot is granted to two ports in the same cycle.
- R7: A port with `req_vld` low drives `gnt_rej` = 0 and `gnt_slot` = 0.
- R8: Two valid requests with identical ages are ordered by port number, and the lower port counts as older.
- R9: The number of granted ports equals the smaller of two counts: the number of valid ports and the number of free slots.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| req_vld | input | NPORT | Per-port request valid |
| req_age | input | NPORT*(AGE_W+1) | Per-port age: wrap flag in the top bit, then the index |
| slot_free | input | NSLOT | Bit s high means slot s can be allocated this cycle |
| gnt_slot | output | NPORT*SW | Per-port granted slot number |
| gnt_rej | output | NPORT | Per-port rollback request |

## Verification
The allocator is driven with the following patterns:
- **Ages in descending port order.** Tells age ordering apart from port ordering.
- **The small-buffer case with two free slots.** Shows that the oldest load is the one that survives.
- **A single valid port on the highest port number.** Exposes compaction that wrongly counts idle ports.
- **Ages that straddle the wrap flag.** Checks the flag handling.
- **Equal ages.** Checks the tie rule.
- **A sweep over all 16 free-slot vectors.** Checks grant uniqueness and the grant count at every occupancy, including a full buffer and an empty one.

// File: rtl/alloc_pkg.sv
package alloc_pkg;
  localparam int unsigned CMP_W = 32;

  // a is older than b under wrap-flag ordering
  function automatic logic age_older(input logic fa, input logic [CMP_W-1:0] ia,
                                     input logic fb, input logic [CMP_W-1:0] ib);
    if (fa == fb) return ia < ib;
    return ia > ib;
  endfunction
endpackage

// File: rtl/alloc_age_rank.sv
module alloc_age_rank #(
  parameter int unsigned NPORT = 3,
  parameter int unsigned AGE_W = 6,
  parameter int unsigned RW    = 2
) (
  input  logic [NPORT-1:0]           vld,
  input  logic [NPORT*(AGE_W+1)-1:0] age,
  output logic [NPORT*RW-1:0]        rank
);
  import alloc_pkg::*;
  localparam int unsigned FW = AGE_W + 1;

  logic [NPORT-1:0]       flag;
  logic [CMP_W-1:0]       idx [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_split
    assign flag[p] = age[p*FW + AGE_W];
    assign idx[p]  = CMP_W'(age[p*FW +: AGE_W]);
  end

  always_comb begin
    rank = '0;
    for (int p = 0; p < NPORT; p++) begin
      logic [RW-1:0] cnt;
      cnt = '0;
      for (int q = 0; q < NPORT; q++) begin
        if (q != p && vld[q]) begin
          if (age_older(flag[q], idx[q], flag[p], idx[p]) ||
              (!age_older(flag[p], idx[p], flag[q], idx[q]) && q < p))
            cnt = cnt + 1'b1;
        end
      end
      rank[p*RW +: RW] = cnt;
    end
  end
endmodule

// File: rtl/alloc_slot_pick.sv
module alloc_slot_pick #(
  parameter int unsigned NPORT = 3,
  parameter int unsigned NSLOT = 4,
  parameter int unsigned SW    = 2
) (
  input  logic [NSLOT-1:0]    free,
  output logic [NPORT*SW-1:0] nth_slot,
  output logic [NPORT-1:0]    nth_ok
);
  always_comb begin
    int seen;
    nth_slot = '0;
    nth_ok   = '0;
    seen     = 0;
    for (int s = 0; s < NSLOT; s++) begin
      if (free[s]) begin
        for (int k = 0; k < NPORT; k++) begin
          if (seen == k) begin
            nth_slot[k*SW +: SW] = SW'(s);
            nth_ok[k]            = 1'b1;
          end
        end
        seen = seen + 1;
      end
    end
  end
endmodule

// File: rtl/load_slot_alloc.sv
module load_slot_alloc #(
  parameter int unsigned NPORT = 3,
  parameter int unsigned NSLOT = 4,
  parameter int unsigned AGE_W = 6,
  localparam int unsigned SW   = (NSLOT > 1) ? $clog2(NSLOT) : 1,
  localparam int unsigned RW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic [NPORT-1:0]           req_vld,
  input  logic [NPORT*(AGE_W+1)-1:0] req_age,
  input  logic [NSLOT-1:0]           slot_free,
  output logic [NPORT*SW-1:0]        gnt_slot,
  output logic [NPORT-1:0]           gnt_rej
);
  logic [NPORT*RW-1:0] rank;
  logic [NPORT*SW-1:0] nth_slot;
  logic [NPORT-1:0]    nth_ok;

  alloc_age_rank #(.NPORT(NPORT), .AGE_W(AGE_W), .RW(RW)) u_rank (
    .vld(req_vld), .age(req_age), .rank(rank)
  );

  alloc_slot_pick #(.NPORT(NPORT), .NSLOT(NSLOT), .SW(SW)) u_pick (
    .free(slot_free), .nth_slot(nth_slot), .nth_ok(nth_ok)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic [RW-1:0] r;
    assign r = rank[p*RW +: RW];
    always_comb begin
      gnt_slot[p*SW +: SW] = '0;
      gnt_rej[p]           = 1'b0;
      if (req_vld[p]) begin
        if (nth_ok[r]) gnt_slot[p*SW +: SW] = nth_slot[r*SW +: SW];
        else           gnt_rej[p]           = 1'b1;
      end
    end
  end
endmodule

// File: rtl/load_slot_alloc_chk.sv
module load_slot_alloc_chk #(
  parameter int unsigned NPORT = 3,
  parameter int unsigned NSLOT = 4,
  parameter int unsigned SW    = 2
) (
  input logic [NPORT-1:0]    req_vld,
  input logic [NSLOT-1:0]    slot_free,
  input logic [NPORT*SW-1:0] gnt_slot,
  input logic [NPORT-1:0]    gnt_rej
);
  logic [NPORT-1:0] granted;
  assign granted = req_vld & ~gnt_rej;

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      if (granted[p])
        p_slot_is_free_r6: assert (slot_free[gnt_slot[p*SW +: SW]]);
      if (!req_vld[p])
        p_idle_quiet_r7: assert (!gnt_rej[p] && gnt_slot[p*SW +: SW] == '0);
      for (int q = p + 1; q < NPORT; q++)
        if (granted[p] && granted[q])
          p_unique_slot_r6: assert (gnt_slot[p*SW +: SW] != gnt_slot[q*SW +: SW]);
    end
    if (|gnt_rej)
      p_reject_only_when_full_r5: assert ($countones(granted) == $countones(slot_free));
    p_grant_count_r9: assert ($countones(granted) ==
        (($countones(req_vld) < $countones(slot_free)) ? $countones(req_vld) : $countones(slot_free)));
  end
endmodule

bind load_slot_alloc load_slot_alloc_chk #(.NPORT(NPORT), .NSLOT(NSLOT), .SW(SW)) u_chk (
  .req_vld(req_vld), .slot_free(slot_free), .gnt_slot(gnt_slot), .gnt_rej(gnt_rej)
);

// File: tb/load_slot_alloc_tb.sv
module load_slot_alloc_tb;
  localparam int NPORT = 3, NSLOT = 4, AGE_W = 6, SW = 2, FW = AGE_W + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [NPORT-1:0]    req_vld;
  logic [NPORT*FW-1:0] req_age;
  logic [NSLOT-1:0]    slot_free;
  logic [NPORT*SW-1:0] gnt_slot;
  logic [NPORT-1:0]    gnt_rej;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  load_slot_alloc #(.NPORT(NPORT), .NSLOT(NSLOT), .AGE_W(AGE_W)) u_dut (
    .req_vld(req_vld), .req_age(req_age), .slot_free(slot_free),
    .gnt_slot(gnt_slot), .gnt_rej(gnt_rej)
  );

  task automatic apply(input logic [2:0] v, input logic f0, input int a0,
                       input logic f1, input int a1, input logic f2, input int a2,
                       input logic [3:0] fr);
    @(negedge clk);
    req_vld = v;
    req_age = {f2, 6'(a2), f1, 6'(a1), f0, 6'(a0)};
    slot_free = fr;
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int p, input logic exp_rej, input int exp_slot);
    logic rj; int sl;
    rj = gnt_rej[p];
    sl = int'(gnt_slot[p*SW +: SW]);
    checks++;
    if (rj !== exp_rej || sl != exp_slot) begin
      fails++;
      $display("FAIL %s port%0d: rej=%0b slot=%0d expected rej=%0b slot=%0d", req, p, rj, sl, exp_rej, exp_slot);
    end
  endtask

  task automatic t_idle();  // R7
    apply(3'b000, 0, 9, 0, 3, 0, 1, 4'b1111);
    for (int p = 0; p < NPORT; p++) chk("R7", p, 1'b0, 0);
  endtask

  task automatic t_age_order();  // R2, R1
    apply(3'b111, 0, 57, 0, 56, 0, 55, 4'b1111);
    chk("R2", 2, 1'b0, 0); chk("R2", 1, 1'b0, 1); chk("R1", 0, 1'b0, 2);
  endtask

  task automatic t_small_buffer();  // R5
    apply(3'b111, 0, 57, 0, 56, 0, 55, 4'b0011);
    chk("R5", 2, 1'b0, 0); chk("R5", 1, 1'b0, 1); chk("R5", 0, 1'b1, 0);
  endtask

  task automatic t_skip_idle();  // R4
    apply(3'b100, 0, 0, 0, 0, 0, 20, 4'b0100);
    chk("R4", 2, 1'b0, 2); chk("R4", 0, 1'b0, 0); chk("R4", 1, 1'b0, 0);
  endtask

  task automatic t_wrap();  // R3: p2(f0,10) older than p1(f0,60) older than p0(f1,2)
    apply(3'b111, 1, 2, 0, 60, 0, 10, 4'b1010);
    chk("R3", 2, 1'b0, 1); chk("R3", 1, 1'b0, 3); chk("R3", 0, 1'b1, 0);
  endtask

  task automatic t_tie();  // R8
    apply(3'b111, 0, 5, 0, 5, 0, 5, 4'b0110);
    chk("R8", 0, 1'b0, 1); chk("R8", 1, 1'b0, 2); chk("R8", 2, 1'b1, 0);
  endtask

  task automatic t_sweep();  // R6, R9
    for (int f = 0; f < 16; f++) begin
      int ng, nf, exp;
      logic [3:0] used;
      apply(3'b111, 0, 30, 0, 12, 0, 40, 4'(f));
      ng = 0; used = '0;
      nf = $countones(4'(f));
      exp = (nf < 3) ? nf : 3;
      for (int p = 0; p < NPORT; p++) begin
        if (!gnt_rej[p]) begin
          int s;
          s = int'(gnt_slot[p*SW +: SW]);
          checks++;
          if (!f[s] || used[s]) begin
            fails++;
            $display("FAIL R6 free=%b port%0d slot=%0d used=%b", 4'(f), p, s, used);
          end
          used[s] = 1'b1;
          ng++;
        end
      end
      checks++;
      if (ng != exp) begin
        fails++;
        $display("FAIL R9 free=%b grants=%0d expected %0d", 4'(f), ng, exp);
      end
    end
  endtask

  initial begin
    req_vld = '0; req_age = '0; slot_free = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_age_order();
    t_small_buffer();
    t_skip_idle();
    t_wrap();
    t_tie();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 5000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule